// File: doc/BRIEF.md
# Preloadable Pitch Divider with Half-Step Dither

This block turns a fast master clock into the base pitch tick of a digital oscillator. An up-counter of `CNT_W` bits is seeded with a divider value and steps once per enabled master clock. It reloads the value on the clock after it reaches its all-ones terminal count. The number of master clocks between ticks is therefore 2^CNT_W minus the seed. The top bit of the seed is always cleared, so with the default 8-bit width the period lies between 129 and 256 clocks. At a 4 MHz master clock that covers a little less than one octave.

When half-step mode is on, a toggle stage flips the lowest seed bit on every second reload. The period then alternates between two neighbouring counts, and the long-run average gains half a clock of resolution without widening the counter. An oscillator enable freezes the whole block when low. A second output exposes the counter's top bit. That bit forms a square-like phase signal: its low span is programmable and its high span is fixed.

Top module: `pitch_divider_top`

## Requirements
- R1: With half-step off and enable high, `tick` pulses once every 2^CNT_W - V master clocks, where V is `div_value` with its top bit cleared; for CNT_W = 8, V = 0 gives 256.
- R2: The top bit of `div_value` has no effect; with CNT_W = 8, a value of 0xC5 gives the same 187-clock period as 0x45, and 0x7F gives the shortest period of 129.
- R3: `tick` is high for exactly one master-clock cycle per period.
- R4: With `half_en` high, the seed's bit 0 is inverted on every second reload, so successive periods alternate between 256 - V and 256 - (V XOR 1).
- R5: `phase_msb` is low from the tick cycle until the count passes half range and then high until the next tick: 128 clocks high and 128 - V clocks low (CNT_W = 8), falling only together with `tick`.
- R6: While `osc_en` is low, `tick` stays low and the count holds, so `phase_msb` is unchanged; counting resumes from the held value.
- R7: `div_value` is sampled only at reload; a change in mid-period leaves the running period untouched and sets the next one.
- R8: While `rst` is high, `tick` is low, the counter is seeded with the current value and the toggle is cleared; the first period after reset is 256 - V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_value | input | CNT_W | Seed value; top bit ignored |
| half_en | input | 1 | Half-step dither enable |
| osc_en | input | 1 | Oscillator enable; low freezes the block |
| tick | output | 1 | One-cycle pulse each period (registered) |
| phase_msb | output | 1 | Top bit of the counter |

## Verification
The counter reaches all-ones on one clock edge. The registered `tick` rises on the next edge, in the same cycle in which the counter already holds the new seed. `phase_msb` comes straight from the counter register, so it changes on the same edge as the count. The bench's behavioural model advances on each rising edge. It compares both outputs at the following falling edge, where every register on the path has settled. Interval checks count falling edges from one observed tick to the next and compare the count with periods worked out from the requirement formulas. Stimulus changes only on falling edges, so a change in mid-period lands at a known position in the count.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Control decoded once in the top and shared by the sub-blocks.
  typedef struct packed {
    logic run;     // oscillator enabled this cycle
    logic reload;  // counter sits at terminal count and will reload
  } pd_ctrl_t;

  localparam int unsigned PD_DEFAULT_W = 8;

endpackage

// File: rtl/pd_load_sel.sv
module pd_load_sel
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W  = PD_DEFAULT_W,
  parameter bit          DITHER = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  pd_ctrl_t         ctrl,
  input  logic             half_en,
  input  logic [CNT_W-1:0] value_in,
  output logic [CNT_W-1:0] load_val
);

  logic flip;

  generate
    if (DITHER) begin : g_toggle
      logic tog_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          tog_q <= 1'b0;
        end else if (ctrl.reload) begin
          tog_q <= half_en ? ~tog_q : 1'b0;
        end
      end
      assign flip = half_en & tog_q & ~rst;
    end else begin : g_plain
      assign flip = 1'b0;
    end
  endgenerate

  // Top bit forced low, bit 0 optionally inverted.
  assign load_val = {1'b0, value_in[CNT_W-2:1], value_in[0] ^ flip};

endmodule

// File: rtl/pd_counter.sv
module pd_counter
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W = PD_DEFAULT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  pd_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_term
);

  localparam logic [CNT_W-1:0] TERM = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= load_val;
    end else if (ctrl.reload) begin
      cnt_q <= load_val;
    end else if (ctrl.run) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign at_term = (cnt_q == TERM);

endmodule

// File: rtl/pd_tick_reg.sv
module pd_tick_reg
  import pd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pd_ctrl_t ctrl,
  output logic     tick_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= ctrl.reload;
    end
  end

endmodule

// File: rtl/pitch_divider_top.sv
module pitch_divider_top
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W  = PD_DEFAULT_W,
  parameter bit          DITHER = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_value,
  input  logic             half_en,
  input  logic             osc_en,
  output logic             tick,
  output logic             phase_msb
);

  pd_ctrl_t         ctrl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign ctrl.run    = osc_en;
  assign ctrl.reload = osc_en & at_term;

  pd_load_sel #(.CNT_W(CNT_W), .DITHER(DITHER)) load_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .half_en  (half_en),
    .value_in (div_value),
    .load_val (load_val)
  );

  pd_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .at_term  (at_term)
  );

  pd_tick_reg tick_i (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .tick_q (tick)
  );

  assign phase_msb = cnt_q[CNT_W-1];

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             osc_en,
  input logic [CNT_W-1:0] div_value,
  input logic             tick,
  input logic             phase_msb,
  input logic [CNT_W-1:0] cnt
);

  // R1: each enabled non-terminal cycle advances the count by one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (osc_en && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

  // R1: an enabled terminal count is followed by a tick
  a_r1_term_tick: assert property (@(posedge clk) disable iff (rst)
    (osc_en && cnt == '1) |=> tick);

  // R3: the tick never lasts two cycles
  a_r3_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R5: the phase bit only falls in a tick cycle
  a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_msb) |-> tick);

  // R2 / R7: the reloaded upper bits come from the value seen at reload, top bit cleared
  a_r7_reload_value: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt[CNT_W-1] == 1'b0 && cnt[CNT_W-2:1] == $past(div_value[CNT_W-2:1])));

  // R6: a disabled cycle neither ticks nor moves the count
  a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> (!tick && $stable(cnt)));

  // R8: the cycle after a reset cycle carries no tick
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !tick);

endmodule

bind pitch_divider_top pd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .osc_en    (osc_en),
  .div_value (div_value),
  .tick      (tick),
  .phase_msb (phase_msb),
  .cnt       (cnt_q)
);

// File: tb/pitch_divider_top_tb_top.sv
`timescale 1ns/1ps
module pitch_divider_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [7:0] div_value = 8'h00;
  logic       half_en = 1'b0;
  logic       osc_en = 1'b1;
  logic       tick;
  logic       phase_msb;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // behavioural reference
  int m_cnt = 0;
  bit m_tog = 1'b0;
  bit m_tick = 1'b0;
  bit m_ok = 1'b0;

  always #10 clk = ~clk;

  pitch_divider_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .div_value (div_value),
    .half_en   (half_en),
    .osc_en    (osc_en),
    .tick      (tick),
    .phase_msb (phase_msb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = int'(div_value) % 128;
      m_tog = 1'b0;
      m_tick = 1'b0;
      m_ok = 1'b1;
    end else if (osc_en) begin
      m_tick = (m_cnt == 255);
      if (m_cnt == 255) begin
        m_cnt = (int'(div_value) % 128) ^ ((half_en && m_tog) ? 1 : 0);
        m_tog = half_en ? !m_tog : 1'b0;
      end else begin
        m_cnt++;
      end
    end else begin
      m_tick = 1'b0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_ok) begin
      chk(tick == m_tick, "R1", int'(tick), int'(m_tick));
      chk(phase_msb == (m_cnt >= 128), "R5", int'(phase_msb), int'(m_cnt >= 128));
    end
  end

  task automatic wait_tick();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick && g < 600);
  endtask

  // count edges to next tick; checks the tick is one cycle wide (R3)
  task automatic next_interval(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk(tick == 1'b0, "R3", int'(tick), 0);
    end while (!tick && n < 600);
  endtask

  task automatic measure(input int n, input int pa, input int pb, input string req);
    int iv;
    bit a_first;
    wait_tick();
    for (int k = 0; k < n; k++) begin
      int exp;
      next_interval(iv);
      if (k == 0) a_first = (iv == pa);
      exp = (((k % 2) == 0) == a_first) ? pa : pb;
      chk(iv == exp, req, iv, exp);
    end
  endtask

  initial begin
    int iv;
    int hi;
    int lo;
    bit held;
    // R8: reset behaviour
    @(negedge clk);
    div_value = 8'h10;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R8", int'(tick), 0);
    chk(phase_msb == 1'b0, "R8", int'(phase_msb), 0);
    rst = 1'b0;
    iv = 0;
    do begin @(negedge clk); iv++; end while (!tick && iv < 600);
    chk(iv == 240, "R8", iv, 240);

    // R1: longest period
    div_value = 8'h00;
    wait_tick();
    measure(3, 256, 256, "R1");
    // R2: shortest period and ignored top bit
    div_value = 8'h7F;
    wait_tick();
    measure(3, 129, 129, "R2");
    div_value = 8'hC5;
    wait_tick();
    measure(3, 187, 187, "R2");

    // R4: half-step alternation, odd and even seeds
    half_en = 1'b1;
    div_value = 8'h33;
    wait_tick();
    measure(6, 205, 206, "R4");
    div_value = 8'h20;
    wait_tick();
    measure(6, 224, 223, "R4");
    half_en = 1'b0;

    // R5: phase bit split within one period
    div_value = 8'h40;
    wait_tick();
    wait_tick();
    hi = 0;
    lo = 1;
    iv = 0;
    do begin
      @(negedge clk);
      iv++;
      if (!tick) begin
        if (phase_msb) hi++; else lo++;
      end
    end while (!tick && iv < 600);
    chk(hi == 128, "R5", hi, 128);
    chk(lo == 64, "R5", lo, 64);

    // R6: freeze with osc_en low
    wait_tick();
    repeat (20) @(negedge clk);
    osc_en = 1'b0;
    held = phase_msb;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      chk(tick == 1'b0, "R6", int'(tick), 0);
      chk(phase_msb == held, "R6", int'(phase_msb), int'(held));
    end
    osc_en = 1'b1;
    iv = 70;
    do begin @(negedge clk); iv++; end while (!tick && iv < 800);
    chk(iv == 242, "R6", iv, 242);

    // R7: value change in mid-period
    div_value = 8'h00;
    wait_tick();
    wait_tick();
    repeat (10) @(negedge clk);
    div_value = 8'h7F;
    iv = 10;
    do begin @(negedge clk); iv++; end while (!tick && iv < 600);
    chk(iv == 256, "R7", iv, 256);
    next_interval(iv);
    chk(iv == 129, "R7", iv, 129);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule